// File: doc/BRIEF.md
# Paged Wiper Register Bank Controller

This block is the register core of a dual-potentiometer trimmer with two wipers per resistor string. It holds four live 8-bit wiper codes that drive the tap decoders, and a 4x4 bank of stored bytes that models retained memory: four levels for each wiper. It also holds a small status register and an auto-advancing pointer. Commands reach it as single-cycle strobes on one command port. The serial slave front end issues set-address, write, read and stop. The stepping front end issues step-up, step-down and store.

The status register decides whether a byte access goes to the live wiper register or to one stored level. Any access to a stored level also loads the live wiper with that byte. A write copies its byte through at once. A read moves the byte it returns into the wiper. Stored writes are collected in a page buffer and are committed only when a stop arrives while the protect-release input is high. A commit or a store starts a busy window. During that window every command is dropped. After each reset the live wipers reload their level-0 bytes.

Top module: `wiper_bank_ctrl`

## Requirements
- R1: During reset and for one cycle after it, `busy` is high. After that first cycle each wiper output equals its level-0 stored byte. The status register reads 00h and the pointer is at address 0.
- R2: Commands use `cmd_op` 1 = set address, which loads the pointer from `cmd_data[2:0]`, and 2 = write. Wiper addresses are 0 → `wiper_0a`, 1 → `wiper_1b`, 2 → `wiper_1a` and 3 → `wiper_0b`. With nv-enable 0, a write sets that wiper on the next clock and does not raise `busy`.
- R3: Address 7 is the status register. A write keeps `cmd_data[2:0]`: bit 0 is nv-enable and bits [2:1] are the stored level. A read returns those bits with bits [7:3] zero. Neither a write nor a read moves the pointer, and neither raises `busy`.
- R4: At addresses 4 to 6, a write has no effect and a read returns 00h. The pointer stays where it is.
- R5: Each write or read at a wiper address advances the pointer by one and wraps from 3 to 0. The wipers are therefore visited in the order 0A, 1B, 1A, 0B.
- R6: With nv-enable 1, a write also loads the addressed live wiper with the byte on the next clock.
- R7: `cmd_op` 4 = stop. If stored bytes are buffered and `nv_unlock` is 1 at the stop, they are committed to the selected level. More than four bytes wrap and overwrite the earlier ones.
- R8: If `nv_unlock` is 0 at the stop, the buffered bytes are discarded. The stored bytes stay unchanged and `busy` stays low.
- R9: `cmd_op` 3 = read. One clock later `rd_valid` pulses and `rd_data` holds the byte. With nv-enable 1, the byte comes from the selected level and is also copied into that live wiper. With nv-enable 0, the byte is the live wiper value.
- R10: A commit or a store holds `busy` high for exactly BUSY_CYCLES cycles. Any command presented while `busy` is high has no effect.
- R11: `cmd_op` 5 and 6 step the wiper at address `cmd_data[1:0]` up or down by one. The step saturates at FFh and at 00h.
- R12: `cmd_op` 7 = store. With `nv_unlock` 1, it copies the wiper at address `cmd_data[1:0]` into its level-0 byte and starts the busy window. With `nv_unlock` 0, it does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; stored bytes survive it |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code |
| cmd_data | input | DATA_W | Address, data byte or wiper select |
| nv_unlock | input | 1 | High permits stored writes and stores |
| rd_data | output | DATA_W | Byte returned by a read |
| rd_valid | output | 1 | One-cycle pulse with `rd_data` |
| busy | output | 1 | Recall or busy window active; commands dropped |
| wiper_0a | output | DATA_W | Code of wiper A, string 0 |
| wiper_0b | output | DATA_W | Code of wiper B, string 0 |
| wiper_1a | output | DATA_W | Code of wiper A, string 1 |
| wiper_1b | output | DATA_W | Code of wiper B, string 1 |

## Verification
The hardest case to reach is a page burst that wraps. It must start in the middle of a page and run past four bytes, and its end state can only be seen by reading the level back. The bench starts a six-byte burst at address 2 and then reads all four bytes of that level. The expected bytes come from the wrap arithmetic. Rejection during the busy window is reached by issuing an address and a stored write straight after a committing stop. The bench then confirms, once `busy` falls, that the wiper and the level are untouched.

// File: rtl/wbank_pkg.sv
package wbank_pkg;
    localparam int NUM_WIPERS = 4;
    localparam int NUM_LEVELS = 4;
    localparam logic [2:0] STATUS_ADDR = 3'd7;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ADDR    = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_STOP    = 3'd4,
        OP_STEP_UP = 3'd5,
        OP_STEP_DN = 3'd6,
        OP_STORE   = 3'd7
    } op_e;

    function automatic logic [2:0] next_ptr(input logic [2:0] a);
        return {1'b0, a[1:0] + 2'd1};
    endfunction
endpackage

// File: rtl/wbank_nv_array.sv
module wbank_nv_array #(
    parameter int DATA_W = 8,
    parameter int WIPERS = 4,
    parameter int LEVELS = 4,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int IDX_W = $clog2(WIPERS)
) (
    input  logic                           clk,
    input  logic [WIPERS-1:0]              wr_en,
    input  logic [LVL_W-1:0]               wr_level,
    input  logic [WIPERS-1:0][DATA_W-1:0]  wr_data,
    input  logic [LVL_W-1:0]               rd_level,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic [DATA_W-1:0]              rd_data,
    output logic [WIPERS-1:0][DATA_W-1:0]  base_out
);
    logic [LEVELS-1:0][WIPERS-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int w = 0; w < WIPERS; w++) begin
            if (wr_en[w]) mem_d[wr_level][w] = wr_data[w];
        end
    end

    // retained storage: deliberately not cleared by reset
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_level][rd_idx];

    generate
        for (genvar g = 0; g < WIPERS; g++) begin : g_base
            assign base_out[g] = mem_q[0][g];
        end
    endgenerate
endmodule

// File: rtl/wbank_page_buf.sv
module wbank_page_buf #(
    parameter int DATA_W = 8,
    parameter int WIPERS = 4,
    parameter int LEVELS = 4,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int IDX_W = $clog2(WIPERS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [LVL_W-1:0]               wr_level,
    input  logic                           clr,
    output logic [WIPERS-1:0]              mask,
    output logic [WIPERS-1:0][DATA_W-1:0]  data,
    output logic [LVL_W-1:0]               level
);
    typedef struct packed {
        logic [WIPERS-1:0]             mask;
        logic [WIPERS-1:0][DATA_W-1:0] data;
        logic [LVL_W-1:0]              level;
    } pb_t;

    pb_t pb_d, pb_q;

    always_comb begin
        pb_d = pb_q;
        if (clr) begin
            pb_d.mask = '0;
        end else if (wr_en) begin
            pb_d.mask[wr_idx] = 1'b1;
            pb_d.data[wr_idx] = wr_data;
            pb_d.level        = wr_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pb_q <= '0;
        else        pb_q <= pb_d;
    end

    assign mask  = pb_q.mask;
    assign data  = pb_q.data;
    assign level = pb_q.level;

    // R7 / R8: a stop always leaves the buffer empty
    a_r7_buffer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mask == '0));
    // R7: a buffered byte is held for its lane
    a_r7_lane_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> mask[$past(wr_idx)] && (data[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/wbank_busy_timer.sv
module wbank_busy_timer #(
    parameter int CYCLES = 64,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start)              cnt_d = CNT_W'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R10: a start always opens the window
    a_r10_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R10: the controller never restarts a running window
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/wiper_bank_ctrl.sv
module wiper_bank_ctrl
    import wbank_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              nv_unlock,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic [DATA_W-1:0] wiper_0a,
    output logic [DATA_W-1:0] wiper_0b,
    output logic [DATA_W-1:0] wiper_1a,
    output logic [DATA_W-1:0] wiper_1b
);
    localparam int WIPERS = NUM_WIPERS;
    localparam int LEVELS = NUM_LEVELS;
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int IDX_W  = $clog2(WIPERS);

    typedef struct packed {
        logic [WIPERS-1:0][DATA_W-1:0] wiper;
        logic [2:0]                    stat;
        logic [2:0]                    ptr;
        logic                          recall;
        logic [DATA_W-1:0]             rd_data;
        logic                          rd_valid;
    } st_t;

    st_t st_d, st_q;

    logic                          accept;
    logic                          timer_busy, timer_start;
    logic [IDX_W-1:0]              sel;
    logic                          nv_en;
    logic [LVL_W-1:0]              cur_level;
    logic [WIPERS-1:0]             nv_wr_en;
    logic [LVL_W-1:0]              nv_wr_level;
    logic [WIPERS-1:0][DATA_W-1:0] nv_wr_data;
    logic [DATA_W-1:0]             nv_rd_data;
    logic [WIPERS-1:0][DATA_W-1:0] nv_base;
    logic                          buf_wr, buf_clr;
    logic [WIPERS-1:0]             buf_mask;
    logic [WIPERS-1:0][DATA_W-1:0] buf_data;
    logic [LVL_W-1:0]              buf_level;
    op_e                           op;

    assign op        = op_e'(cmd_op);
    assign nv_en     = st_q.stat[0];
    assign cur_level = st_q.stat[2:1];
    assign sel       = cmd_data[IDX_W-1:0];
    assign busy      = st_q.recall | timer_busy;
    assign accept    = cmd_valid && !busy;

    wbank_nv_array #(.DATA_W(DATA_W), .WIPERS(WIPERS), .LEVELS(LEVELS)) u_nv (
        .clk      (clk),
        .wr_en    (nv_wr_en),
        .wr_level (nv_wr_level),
        .wr_data  (nv_wr_data),
        .rd_level (cur_level),
        .rd_idx   (st_q.ptr[IDX_W-1:0]),
        .rd_data  (nv_rd_data),
        .base_out (nv_base)
    );

    wbank_page_buf #(.DATA_W(DATA_W), .WIPERS(WIPERS), .LEVELS(LEVELS)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (buf_wr),
        .wr_idx   (st_q.ptr[IDX_W-1:0]),
        .wr_data  (cmd_data),
        .wr_level (cur_level),
        .clr      (buf_clr),
        .mask     (buf_mask),
        .data     (buf_data),
        .level    (buf_level)
    );

    wbank_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (timer_start),
        .busy  (timer_busy)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        buf_wr        = 1'b0;
        buf_clr       = 1'b0;
        nv_wr_en      = '0;
        nv_wr_level   = buf_level;
        nv_wr_data    = buf_data;
        timer_start   = 1'b0;

        if (st_q.recall) begin
            st_d.wiper  = nv_base;
            st_d.recall = 1'b0;
        end else if (accept) begin
            unique case (op)
                OP_ADDR: st_d.ptr = cmd_data[2:0];
                OP_WRITE: begin
                    if (st_q.ptr == STATUS_ADDR) begin
                        st_d.stat = cmd_data[2:0];
                    end else if (!st_q.ptr[2]) begin
                        st_d.wiper[st_q.ptr[IDX_W-1:0]] = cmd_data;
                        buf_wr   = nv_en;
                        st_d.ptr = next_ptr(st_q.ptr);
                    end
                end
                OP_READ: begin
                    st_d.rd_valid = 1'b1;
                    if (st_q.ptr == STATUS_ADDR) begin
                        st_d.rd_data = {{(DATA_W-3){1'b0}}, st_q.stat};
                    end else if (st_q.ptr[2]) begin
                        st_d.rd_data = '0;
                    end else begin
                        if (nv_en) begin
                            st_d.rd_data = nv_rd_data;
                            st_d.wiper[st_q.ptr[IDX_W-1:0]] = nv_rd_data;
                        end else begin
                            st_d.rd_data = st_q.wiper[st_q.ptr[IDX_W-1:0]];
                        end
                        st_d.ptr = next_ptr(st_q.ptr);
                    end
                end
                OP_STOP: begin
                    buf_clr = 1'b1;
                    if (buf_mask != '0 && nv_unlock) begin
                        nv_wr_en    = buf_mask;
                        timer_start = 1'b1;
                    end
                end
                OP_STEP_UP: begin
                    if (st_q.wiper[sel] != {DATA_W{1'b1}})
                        st_d.wiper[sel] = st_q.wiper[sel] + 1'b1;
                end
                OP_STEP_DN: begin
                    if (st_q.wiper[sel] != '0)
                        st_d.wiper[sel] = st_q.wiper[sel] - 1'b1;
                end
                OP_STORE: begin
                    if (nv_unlock) begin
                        nv_wr_en[sel]   = 1'b1;
                        nv_wr_level     = '0;
                        nv_wr_data[sel] = st_q.wiper[sel];
                        timer_start     = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.recall <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rd_data;
    assign rd_valid = st_q.rd_valid;
    assign wiper_0a = st_q.wiper[0];
    assign wiper_1b = st_q.wiper[1];
    assign wiper_1a = st_q.wiper[2];
    assign wiper_0b = st_q.wiper[3];

    // R1: leaving recall, each wiper holds its level-0 byte
    a_r1_recall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.recall) |-> (st_q.wiper == $past(nv_base)));
    // R3: a status write keeps the low three bits
    a_r3_status_write: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_WRITE && st_q.ptr == STATUS_ADDR)
            |=> (st_q.stat == $past(cmd_data[2:0])));
    // R5: the pointer wraps from the last wiper to the first
    a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op == OP_WRITE || op == OP_READ) && st_q.ptr == 3'd3)
            |=> (st_q.ptr == 3'd0));
    // R6: a stored write is seen on the live wiper one clock later
    a_r6_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_WRITE && !st_q.ptr[2] && nv_en)
            |=> (st_q.wiper[$past(st_q.ptr[IDX_W-1:0])] == $past(cmd_data)));
    // R8 / R12: the stored bank is touched only when released
    a_r8_protect: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_wr_en != '0) |-> nv_unlock);
    // R10: a command arriving in the busy window changes no wiper
    a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && timer_busy) |=> (st_q.wiper == $past(st_q.wiper)));
    // R11: stepping up saturates at the top code
    a_r11_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_STEP_UP && st_q.wiper[sel] == {DATA_W{1'b1}})
            |=> (st_q.wiper[$past(sel)] == {DATA_W{1'b1}}));
endmodule

// File: tb/tb_wiper_bank_ctrl.sv
module tb_wiper_bank_ctrl;
    localparam int DW = 8;
    localparam int BC = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [DW-1:0] cmd_data = '0;
    logic          nv_unlock = 1'b1;
    logic [DW-1:0] rd_data, wiper_0a, wiper_0b, wiper_1a, wiper_1b;
    logic          rd_valid, busy;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] nv_m [4][4];

    always #10 clk = ~clk;

    wiper_bank_ctrl #(.DATA_W(DW), .BUSY_CYCLES(BC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .nv_unlock(nv_unlock), .rd_data(rd_data),
        .rd_valid(rd_valid), .busy(busy), .wiper_0a(wiper_0a),
        .wiper_0b(wiper_0b), .wiper_1a(wiper_1a), .wiper_1b(wiper_1b)
    );

    function automatic logic [7:0] wip(input int i);
        case (i)
            0: return wiper_0a;
            1: return wiper_1b;
            2: return wiper_1a;
            default: return wiper_0b;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic set_mode(input int lvl, input bit nv);
        cmd(3'd1, 8'd7);
        cmd(3'd2, 8'(lvl * 2 + int'(nv)));
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {7'd0, busy}, 8'd1);
        rst_n = 1'b1;
        @(negedge clk);
        wait_idle();
    endtask

    function automatic logic [7:0] pval(input int l, input int i);
        return 8'(l * 40 + i * 7 + 3);
    endfunction

    initial begin
        do_reset();
        // R1 / R2 / R5: pointer starts at 0 and walks 0A,1B,1A,0B then wraps
        for (int k = 0; k < 5; k++) begin
            cmd(3'd2, 8'(8'h11 * (k + 1)));
            chk("R5 walk order", wip(k % 4), 8'(8'h11 * (k + 1)));
            chk("R2 volatile no busy", {7'd0, busy}, 8'd0);
        end
        // R1 / R3: status reset value, write keeps low bits
        cmd(3'd1, 8'd7); cmd(3'd3, 8'd0);
        chk("R1 status reset", rd_data, 8'h00);
        cmd(3'd2, 8'hF8); cmd(3'd2, 8'hF9); cmd(3'd3, 8'd0);
        chk("R3 status bits", rd_data, 8'h01);
        chk("R3 rd_valid", {7'd0, rd_valid}, 8'd1);
        set_mode(0, 0);
        // R4: unused addresses
        cmd(3'd1, 8'd5); cmd(3'd2, 8'h77); cmd(3'd3, 8'd0);
        chk("R4 unused read", rd_data, 8'h00);
        chk("R4 ptr held", rd_data, 8'h00);
        for (int i = 0; i < 4; i++) chk("R4 wiper untouched", wip(i), (i == 0) ? 8'h55 : 8'(8'h11 * (i + 1)));
        // R6 / R7 / R10: fill every level with a page
        for (int l = 0; l < 4; l++) begin
            set_mode(l, 1);
            cmd(3'd1, 8'd0);
            for (int i = 0; i < 4; i++) begin
                cmd(3'd2, pval(l, i));
                chk("R6 write-through", wip(i), pval(l, i));
                nv_m[l][i] = pval(l, i);
            end
            cmd(3'd4, 8'd0);
            if (l == 0) begin
                int n = 0;
                while (busy) begin n++; @(negedge clk); end
                chk("R10 busy length", 8'(n), 8'(BC));
            end else if (l == 1) begin
                cmd(3'd1, 8'd0); cmd(3'd2, 8'h99);
                wait_idle();
                chk("R10 reject in busy", wip(0), pval(1, 0));
            end else begin
                wait_idle();
            end
        end
        // R7: wrapping burst of six bytes from address 2 at level 2
        set_mode(2, 1);
        cmd(3'd1, 8'd2);
        for (int k = 0; k < 6; k++) begin
            cmd(3'd2, 8'(8'hA0 + k));
            nv_m[2][(2 + k) % 4] = 8'(8'hA0 + k);
        end
        cmd(3'd4, 8'd0); wait_idle();
        // R8: protected stop discards level 3 bytes
        nv_unlock = 1'b0;
        set_mode(3, 1); cmd(3'd1, 8'd0);
        for (int i = 0; i < 4; i++) cmd(3'd2, 8'(8'h50 + i));
        cmd(3'd4, 8'd0);
        chk("R8 no busy", {7'd0, busy}, 8'd0);
        nv_unlock = 1'b1;
        // R9 / R7 / R8: read every level back, reads move into wipers
        for (int l = 0; l < 4; l++) begin
            set_mode(0, 0); cmd(3'd1, 8'd0);
            for (int i = 0; i < 4; i++) cmd(3'd2, 8'hEE);
            set_mode(l, 1); cmd(3'd1, 8'd0);
            for (int i = 0; i < 4; i++) begin
                cmd(3'd3, 8'd0);
                chk("R9 stored read (R7 R8 contents)", rd_data, nv_m[l][i]);
                chk("R9 read moves to wiper", wip(i), nv_m[l][i]);
            end
        end
        // R9: volatile read
        set_mode(0, 0);
        cmd(3'd1, 8'd1); cmd(3'd2, 8'h3C); cmd(3'd1, 8'd1); cmd(3'd3, 8'd0);
        chk("R9 volatile read", rd_data, 8'h3C);
        // R11: stepping with saturation
        cmd(3'd1, 8'd2); cmd(3'd2, 8'hFE); cmd(3'd2, 8'h01);
        cmd(3'd1, 8'd0); cmd(3'd2, 8'h80);
        cmd(3'd5, 8'd2); cmd(3'd5, 8'd2);
        chk("R11 up saturate", wiper_1a, 8'hFF);
        cmd(3'd6, 8'd3); cmd(3'd6, 8'd3);
        chk("R11 down saturate", wiper_0b, 8'h00);
        cmd(3'd5, 8'd0);
        chk("R11 step mid", wiper_0a, 8'h81);
        // R12: store locked then released
        cmd(3'd1, 8'd1); cmd(3'd2, 8'h6D);
        nv_unlock = 1'b0; cmd(3'd7, 8'd1);
        chk("R12 locked store no busy", {7'd0, busy}, 8'd0);
        nv_unlock = 1'b1; cmd(3'd7, 8'd1);
        chk("R12 store busy", {7'd0, busy}, 8'd1);
        wait_idle();
        nv_m[0][1] = 8'h6D;
        // R1: recall after reset
        do_reset();
        for (int i = 0; i < 4; i++) chk("R1 recall", wip(i), nv_m[0][i]);
        cmd(3'd1, 8'd7); cmd(3'd3, 8'd0);
        chk("R1 status after reset", rd_data, 8'h00);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule